// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a SPI master that software drives through a small 32-bit register bus. Words written to a data port queue up in a transmit FIFO. A serializer sends each word as one frame of 1 to 32 bits in SPI mode 0, with the clock idling low. Frames received on the data input, or taken from the internal loopback path, are stored in a receive FIFO, and software reads them back through the same data port.

Software sets the clock divider, the frame length and the bit order. It has separate enables for the transmit and receive paths, so it can send data without collecting anything in return. It also drives the four chip-select lines by hand: a 2-bit field picks one line and a level bit sets what that line carries. A status word reports the FIFO fill levels and a busy flag. Two constant words give a revision number and the FIFO depths, so that a driver can size its bursts.

Top module: `spim_ctrl`

## Requirements
- R1: Offset 0x60 reads the constant 0x00011900. Offset 0x64 reads TX depth minus one in bits 23:16, RX depth minus one in bits 15:8, 31 in bits 7:0, and a 1 in bit 26. Offsets 0x10 and 0x14, and any unmapped offset, read 0.
- R2: Control 0 (0x00) reads back loopback at bit 7 and LSB-first at bit 6. Control 1 (0x04) reads back the divider at bits 15:0 and the frame length minus one at bits 20:16. Control 2 (0x08) reads back enable (bit 0), TX output enable (1), RX enable (7), TX enable (8), chip-select level (9) and chip-select number (11:10). Its flush bits 2 and 3 always read 0.
- R3: Status (0x0C) gives RX-full at bit 0, TX-not-full at bit 1, busy at bit 2, the RX fill count at bits 8:4 and the TX fill count at bits 16:12. Busy is 1 while a frame is shifting or the TX FIFO is not empty.
- R4: The chip-select output whose index equals control 2 bits 11:10 carries the level in bit 9. All other chip-select outputs stay high.
- R5: SCLK is low whenever no frame is active. Successive rising edges within a frame are 2*(DIV+1) system clocks apart.
- R6: Each frame has exactly FLEN+1 SCLK pulses. A write to the data port (0x18) stores only the low FLEN+1 bits.
- R7: MOSI changes only while SCLK is low. With bit 6 clear, bit FLEN of the word goes out first, down to bit 0. With bit 6 set, bit 0 goes out first.
- R8: With loopback set, the receive path takes the serializer's own output bit. With loopback clear, it samples MISO on each SCLK rising edge. The received word keeps the bit positions of the transmitted word.
- R9: A frame starts only while enable and TX enable are both 1. Otherwise, queued words stay in the TX FIFO and SCLK does not toggle.
- R10: When RX enable is 0, completed frames are not stored and the RX fill count does not change.
- R11: A data-port write to a full TX FIFO is ignored.
- R12: A frame that completes while the RX FIFO is full is discarded. A read of an empty RX FIFO returns 0 and changes nothing.
- R13: Writing 1 to control 2 bit 3 empties the TX FIFO. Writing 1 to bit 2 empties the RX FIFO.
- R14: When TX output enable is 0, MOSI stays 0. Frames still run, and loopback still sees the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | CS_NUM | Chip selects, active low |

## Verification
The bench builds the controller with 4-entry TX and RX FIFOs and all four chip selects. With these small FIFOs, overflow of both queues, the full flags and the discard rules can be reached after a few writes. It sweeps both bit orders across frame lengths of 1, 4, 8, 13 and 32 bits and dividers of 0, 1 and 3. For each frame it checks the SCLK pulse count, the edge spacing and the MOSI bit sequence, all computed arithmetically. It also sweeps all eight combinations of chip-select number and level.

// File: rtl/spim_pkg.sv
package spim_pkg;
   localparam int unsigned BUS_AW = 8;
   localparam int unsigned BUS_DW = 32;
   localparam int unsigned FRAME_MAX = 32;
   localparam int unsigned FLEN_W = 5;
   localparam int unsigned DIV_W = 16;
   localparam int unsigned LVL_W = 5;

   localparam logic [BUS_AW-1:0] A_CTL0  = 8'h00;
   localparam logic [BUS_AW-1:0] A_CTL1  = 8'h04;
   localparam logic [BUS_AW-1:0] A_CTL2  = 8'h08;
   localparam logic [BUS_AW-1:0] A_STAT  = 8'h0C;
   localparam logic [BUS_AW-1:0] A_DATA  = 8'h18;
   localparam logic [BUS_AW-1:0] A_REV   = 8'h60;
   localparam logic [BUS_AW-1:0] A_FEAT  = 8'h64;

   localparam int unsigned B_LSB    = 6;
   localparam int unsigned B_LOOP   = 7;
   localparam int unsigned B_FLEN   = 16;
   localparam int unsigned B_EN     = 0;
   localparam int unsigned B_TXOE   = 1;
   localparam int unsigned B_RXCLR  = 2;
   localparam int unsigned B_TXCLR  = 3;
   localparam int unsigned B_RXEN   = 7;
   localparam int unsigned B_TXEN   = 8;
   localparam int unsigned B_CSLVL  = 9;
   localparam int unsigned B_CSSEL  = 10;
   localparam int unsigned B_RXCNT  = 4;
   localparam int unsigned B_TXCNT  = 12;
   localparam int unsigned B_SPICAP = 26;

   typedef struct packed {
      logic              loop;
      logic              lsb;
      logic [DIV_W-1:0]  div;
      logic [FLEN_W-1:0] flen;
      logic              en;
      logic              txoe;
      logic              rxen;
      logic              txen;
      logic              cs_lvl;
      logic [1:0]        cs_sel;
   } spim_cfg_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr,
   input  logic                          push,
   input  logic [W-1:0]                  din,
   input  logic                          pop,
   output logic [W-1:0]                  dout,
   output logic [$clog2(DEPTH+1)-1:0]    count,
   output logic                          full,
   output logic                          empty
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH+1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spim_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (clr) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         unique case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
   import spim_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [FRAME_MAX-1:0]  word,
   input  logic [FLEN_W-1:0]     flen,
   input  logic                  lsb,
   input  logic [DIV_W-1:0]      div,
   input  logic                  txoe,
   input  logic                  loop,
   input  logic                  miso,
   output logic                  busy,
   output logic                  sclk,
   output logic                  mosi,
   output logic                  done,
   output logic [FRAME_MAX-1:0]  rx_word
);
   logic [FRAME_MAX-1:0] txw, rxw;
   logic [FLEN_W-1:0]    bitn, idx;
   logic [DIV_W-1:0]     cnt;
   logic                 bit_out, rx_in, edge_now;

   // position of the current bit in the frame word
   assign idx      = lsb ? bitn : (flen - bitn);
   assign bit_out  = txw[idx];
   assign mosi     = busy & txoe & bit_out;
   assign rx_in    = loop ? bit_out : miso;
   assign edge_now = busy & (cnt == div);
   assign done     = edge_now & sclk & (bitn == flen);
   assign rx_word  = rxw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sclk <= 1'b0;
         txw  <= '0;
         rxw  <= '0;
         bitn <= '0;
         cnt  <= '0;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            sclk <= 1'b0;
            txw  <= word;
            rxw  <= '0;
            bitn <= '0;
            cnt  <= '0;
         end
      end else if (!edge_now) begin
         cnt <= cnt + 16'd1;
      end else begin
         cnt <= '0;
         if (!sclk) begin
            sclk     <= 1'b1;
            rxw[idx] <= rx_in;
         end else begin
            sclk <= 1'b0;
            if (bitn == flen) busy <= 1'b0;
            else              bitn <= bitn + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
   import spim_pkg::*;
#(
   parameter int unsigned TX_DEPTH = 16,
   parameter int unsigned RX_DEPTH = 16,
   parameter int unsigned CS_NUM   = 4,
   parameter logic [31:0] REV_WORD = 32'h0001_1900
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [7:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [CS_NUM-1:0] spi_cs_n
);
   localparam int unsigned TCW = $clog2(TX_DEPTH+1);
   localparam int unsigned RCW = $clog2(RX_DEPTH+1);

   if (TX_DEPTH > 16 || RX_DEPTH > 16) begin : g_bad_fill
      $error("spim_ctrl: fill counts must fit the 5-bit status fields");
   end
   if (CS_NUM < 1 || CS_NUM > 4) begin : g_bad_cs
      $error("spim_ctrl: CS_NUM must be 1 to 4");
   end

   spim_cfg_t cfg;

   logic wr, rd;
   logic tx_push, tx_pop, tx_flush, tx_full, tx_empty;
   logic rx_push, rx_pop, rx_flush, rx_full, rx_empty;
   logic [TCW-1:0] tx_cnt;
   logic [RCW-1:0] rx_cnt;
   logic [LVL_W-1:0] tx_lvl, rx_lvl;
   logic [FRAME_MAX-1:0] tx_head, rx_head, rx_word, fmask;
   logic eng_busy, eng_done, start;
   logic [31:0] stat, feat;

   assign wr = bus_req & bus_we;
   assign rd = bus_req & ~bus_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg        <= '0;
         cfg.cs_lvl <= 1'b1;
      end else if (wr) begin
         unique case (bus_addr)
            A_CTL0: begin
               cfg.loop <= bus_wdata[B_LOOP];
               cfg.lsb  <= bus_wdata[B_LSB];
            end
            A_CTL1: begin
               cfg.div  <= bus_wdata[DIV_W-1:0];
               cfg.flen <= bus_wdata[B_FLEN +: FLEN_W];
            end
            A_CTL2: begin
               cfg.en     <= bus_wdata[B_EN];
               cfg.txoe   <= bus_wdata[B_TXOE];
               cfg.rxen   <= bus_wdata[B_RXEN];
               cfg.txen   <= bus_wdata[B_TXEN];
               cfg.cs_lvl <= bus_wdata[B_CSLVL];
               cfg.cs_sel <= bus_wdata[B_CSSEL +: 2];
            end
            default: ;
         endcase
      end
   end

   // data writes keep only the bits that belong to the frame
   assign fmask    = {FRAME_MAX{1'b1}} >> (5'd31 - cfg.flen);
   assign tx_push  = wr & (bus_addr == A_DATA);
   assign rx_pop   = rd & (bus_addr == A_DATA);
   assign tx_flush = wr & (bus_addr == A_CTL2) & bus_wdata[B_TXCLR];
   assign rx_flush = wr & (bus_addr == A_CTL2) & bus_wdata[B_RXCLR];
   assign start    = ~eng_busy & cfg.en & cfg.txen & ~tx_empty;
   assign tx_pop   = start;
   assign rx_push  = eng_done & cfg.rxen;

   spim_fifo #(.W(FRAME_MAX), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(tx_flush),
      .push(tx_push), .din(bus_wdata & fmask),
      .pop(tx_pop), .dout(tx_head), .count(tx_cnt),
      .full(tx_full), .empty(tx_empty)
   );

   spim_fifo #(.W(FRAME_MAX), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(rx_flush),
      .push(rx_push), .din(rx_word),
      .pop(rx_pop), .dout(rx_head), .count(rx_cnt),
      .full(rx_full), .empty(rx_empty)
   );

   spim_shift u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .word(tx_head),
      .flen(cfg.flen), .lsb(cfg.lsb), .div(cfg.div), .txoe(cfg.txoe),
      .loop(cfg.loop), .miso(spi_miso), .busy(eng_busy),
      .sclk(spi_sclk), .mosi(spi_mosi), .done(eng_done), .rx_word(rx_word)
   );

   assign tx_lvl = LVL_W'(tx_cnt);
   assign rx_lvl = LVL_W'(rx_cnt);

   for (genvar i = 0; i < CS_NUM; i++) begin : g_cs
      assign spi_cs_n[i] = (cfg.cs_sel == 2'(i)) ? cfg.cs_lvl : 1'b1;
   end

   always_comb begin
      stat                   = '0;
      stat[0]                = rx_full;
      stat[1]                = ~tx_full;
      stat[2]                = eng_busy | ~tx_empty;
      stat[B_RXCNT +: LVL_W] = rx_lvl;
      stat[B_TXCNT +: LVL_W] = tx_lvl;
      feat                   = '0;
      feat[7:0]              = 8'(FRAME_MAX - 1);
      feat[15:8]             = 8'(RX_DEPTH - 1);
      feat[23:16]            = 8'(TX_DEPTH - 1);
      feat[B_SPICAP]         = 1'b1;
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_CTL0: begin
            bus_rdata[B_LOOP] = cfg.loop;
            bus_rdata[B_LSB]  = cfg.lsb;
         end
         A_CTL1: begin
            bus_rdata[DIV_W-1:0]        = cfg.div;
            bus_rdata[B_FLEN +: FLEN_W] = cfg.flen;
         end
         A_CTL2: begin
            bus_rdata[B_EN]         = cfg.en;
            bus_rdata[B_TXOE]       = cfg.txoe;
            bus_rdata[B_RXEN]       = cfg.rxen;
            bus_rdata[B_TXEN]       = cfg.txen;
            bus_rdata[B_CSLVL]      = cfg.cs_lvl;
            bus_rdata[B_CSSEL +: 2] = cfg.cs_sel;
         end
         A_STAT:  bus_rdata = stat;
         A_DATA:  bus_rdata = rx_empty ? '0 : rx_head;
         A_REV:   bus_rdata = REV_WORD;
         A_FEAT:  bus_rdata = feat;
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk #(
   parameter int unsigned TX_DEPTH = 16,
   parameter int unsigned RX_DEPTH = 16,
   parameter int unsigned CS_NUM   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CS_NUM-1:0] cs_n,
   input logic              sclk,
   input logic              mosi,
   input logic              eng_busy,
   input logic [4:0]        tx_lvl,
   input logic [4:0]        rx_lvl,
   input logic              tx_pop,
   input logic              tx_flush,
   input logic              rx_pop,
   input logic              rx_flush
);
   assert_cs_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cs_n) <= 1);

   assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> !sclk);

   assert_mosi_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> $stable(mosi));

   assert_tx_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_lvl <= 5'(TX_DEPTH));

   assert_tx_full_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_lvl == 5'(TX_DEPTH) && !tx_pop && !tx_flush) |=> tx_lvl == 5'(TX_DEPTH));

   assert_rx_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rx_lvl <= 5'(RX_DEPTH));

   assert_rx_full_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_lvl == 5'(RX_DEPTH) && !rx_pop && !rx_flush) |=> rx_lvl == 5'(RX_DEPTH));

   assert_mosi_quiet_R14: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> !mosi);
endmodule

bind spim_ctrl spim_ctrl_chk #(
   .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .CS_NUM(CS_NUM)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk),
   .mosi(spi_mosi), .eng_busy(eng_busy), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
   .tx_pop(tx_pop), .tx_flush(tx_flush), .rx_pop(rx_pop), .rx_flush(rx_flush)
);

// File: tb/spim_ctrl_bench.sv
`timescale 1ns/1ps
module spim_ctrl_bench;
   localparam int TXD = 4;
   localparam int RXD = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sclk, mosi;
   logic        miso = 1'b0;
   logic [3:0]  cs_n;

   int n_checks = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   spim_ctrl #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .CS_NUM(4)) u_spim_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
   );

   // pin monitor: SCLK rising edges, their spacing, MOSI bits seen at them
   int          cyc = 0, rises = 0, last_rise = 0, per = 0, mosi_ones = 0;
   logic        sclk_d = 1'b0;
   logic [31:0] mon_word = '0;
   always @(posedge clk) begin
      cyc    <= cyc + 1;
      sclk_d <= sclk;
      if (sclk && !sclk_d) begin
         rises     <= rises + 1;
         per       <= cyc - last_rise;
         last_rise <= cyc;
         mon_word  <= {mon_word[30:0], mosi};
         if (mosi) mosi_ones <= mosi_ones + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_req = 1'b0;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int k = 0; k < 4000; k++) begin
         rd(8'h0C, s);
         if (!s[2]) return;
      end
      chk("R9 idle timeout", 32'd1, 32'd0);
   endtask

   function automatic logic [31:0] fmask(input int fl);
      return 32'hFFFF_FFFF >> (31 - fl);
   endfunction

   function automatic logic [31:0] brev(input logic [31:0] d, input int fl);
      logic [31:0] r = '0;
      for (int k = 0; k <= fl; k++) r[fl-k] = d[k];
      return r;
   endfunction

   task automatic frame(input bit lsb, input int fl, input int dv, input logic [31:0] d,
                        input bit loop, input bit rx_exp_loop);
      logic [31:0] v;
      int r0;
      wr(8'h00, (32'(loop) << 7) | (32'(lsb) << 6));
      wr(8'h04, (32'(fl) << 16) | 32'(dv));
      r0 = rises;
      wr(8'h18, d);
      wait_idle();
      chk("R6 pulse count", 32'(rises - r0), 32'(fl + 1));
      if (fl > 0) chk("R5 sclk period", 32'(per), 32'(2 * (dv + 1)));
      chk("R7 mosi order", mon_word & fmask(fl),
          lsb ? brev(d, fl) : (d & fmask(fl)));
      if (rx_exp_loop) begin
         rd(8'h18, v);
         chk("R8 loopback data", v, d & fmask(fl));
      end
   endtask

   initial begin
      #1_500_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int r0, o0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state and constant words
      rd(8'h60, v); chk("R1 revision", v, 32'h0001_1900);
      rd(8'h64, v); chk("R1 feature", v, (32'd1 << 26) | (32'(TXD-1) << 16) | (32'(RXD-1) << 8) | 32'd31);
      rd(8'h10, v); chk("R1 int ctrl zero", v, 32'd0);
      rd(8'h14, v); chk("R1 int status zero", v, 32'd0);
      rd(8'h0C, v); chk("R3 reset status", v, 32'h0000_0002);
      chk("R4 reset cs", 32'(cs_n), 32'hF);
      chk("R5 reset sclk", 32'(sclk), 32'd0);

      // control readback
      wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); chk("R2 ctl0", v, 32'h0000_00C0);
      wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); chk("R2 ctl1", v, 32'h001F_FFFF);
      wr(8'h08, 32'h0000_FFFF); rd(8'h08, v); chk("R2 ctl2", v, 32'h0000_0F83);

      // chip-select sweep
      for (int s = 0; s < 4; s++) begin
         for (int l = 0; l < 2; l++) begin
            wr(8'h08, (32'(s) << 10) | (32'(l) << 9));
            @(negedge clk);
            chk("R4 cs decode", 32'(cs_n), l ? 32'hF : (32'hF & ~(32'd1 << s)));
         end
      end

      // disabled with TX enable: words wait, overflow ignored
      wr(8'h04, 32'h0007_0000);
      wr(8'h08, 32'h0000_0100);
      r0 = rises;
      for (int k = 0; k < 6; k++) wr(8'h18, 32'(k + 1));
      repeat (20) @(negedge clk);
      rd(8'h0C, v); chk("R11 tx full status", v, 32'h0000_4004);
      chk("R9 no sclk while disabled", 32'(rises - r0), 32'd0);
      wr(8'h08, 32'h0000_0108);
      rd(8'h0C, v); chk("R13 tx flush", v, 32'h0000_0002);
      wr(8'h08, 32'h0000_0001);
      wr(8'h18, 32'h55);
      repeat (20) @(negedge clk);
      rd(8'h0C, v); chk("R9 no start without tx enable", v, 32'h0000_1006);
      chk("R9 no sclk without tx enable", 32'(rises - r0), 32'd0);
      wr(8'h08, 32'h0000_0009);

      // loopback sweep: order x length x divider
      wr(8'h08, 32'h0000_0183);
      for (int lsb = 0; lsb < 2; lsb++) begin
         for (int fi = 0; fi < 5; fi++) begin
            for (int di = 0; di < 3; di++) begin
               int fl = (fi == 0) ? 0 : (fi == 1) ? 3 : (fi == 2) ? 7 : (fi == 3) ? 12 : 31;
               int dv = (di == 0) ? 0 : (di == 1) ? 1 : 3;
               logic [31:0] d = 32'h9E37_79B9 * 32'(fi * 3 + di + 1 + lsb * 16);
               frame(lsb[0], fl, dv, d, 1'b1, 1'b1);
            end
         end
      end
      frame(1'b0, 3, 0, 32'hFFFF_FFFF, 1'b1, 1'b1);

      // MISO path with loopback off
      miso = 1'b1;
      frame(1'b0, 7, 1, 32'h0000_0000, 1'b0, 1'b0);
      rd(8'h18, v); chk("R8 miso ones", v, 32'h0000_00FF);
      miso = 1'b0;
      frame(1'b1, 7, 1, 32'h0000_00FF, 1'b0, 1'b0);
      rd(8'h18, v); chk("R8 miso zeros", v, 32'h0000_0000);

      // write-only: RX disabled
      wr(8'h08, 32'h0000_0103);
      frame(1'b0, 7, 0, 32'h0000_00A5, 1'b1, 1'b0);
      rd(8'h0C, v); chk("R10 rx not stored", v, 32'h0000_0002);

      // TX output enable off: pin quiet, loopback still works
      wr(8'h08, 32'h0000_0181);
      wr(8'h00, 32'h0000_0080);
      wr(8'h04, 32'h0007_0000);
      o0 = mosi_ones;
      wr(8'h18, 32'h0000_00FF);
      wait_idle();
      chk("R14 mosi quiet", 32'(mosi_ones - o0), 32'd0);
      rd(8'h18, v); chk("R14 loopback data", v, 32'h0000_00FF);

      // RX overflow and empty read
      wr(8'h08, 32'h0000_0183);
      for (int k = 0; k < 4; k++) wr(8'h18, 32'(8'h10 + k));
      wait_idle();
      wr(8'h18, 32'h77); wr(8'h18, 32'h88);
      wait_idle();
      rd(8'h0C, v); chk("R12 rx full status", v, 32'h0000_0043);
      for (int k = 0; k < 4; k++) begin
         rd(8'h18, v); chk("R12 rx order", v, 32'(8'h10 + k));
      end
      rd(8'h18, v); chk("R12 empty read", v, 32'd0);
      rd(8'h0C, v); chk("R12 empty unchanged", v, 32'h0000_0002);

      // RX flush
      wr(8'h18, 32'h11); wr(8'h18, 32'h22);
      wait_idle();
      rd(8'h0C, v); chk("R3 rx count", v, 32'h0000_0022);
      wr(8'h08, 32'h0000_0187);
      rd(8'h0C, v); chk("R13 rx flush", v, 32'h0000_0002);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule